// File: doc/BRIEF.md
# Fine-grained warp issue scheduler

This block keeps a fixed set of hardware thread contexts (warps), each with its own program counter and its own ready state. All warps share one execution pipeline. In every clock cycle the block selects one eligible warp and issues that warp's next instruction into the pipeline. Moving from one warp to another costs no cycle. A warp that has an instruction in flight is held back until that instruction leaves the pipeline. There is no forwarding, so each warp waits out the full latency between its own instructions.

The pipeline is modelled as a delay line of `PIPE_LAT` stages. The delay line returns a completion that carries the warp index. In the cycle a completion arrives, that warp is eligible again. The pipeline therefore stays full only when at least `PIPE_LAT` warps are running. With fewer warps, idle issue slots appear. Two counters record how many slots issued an instruction and how many stayed idle.

Each warp is launched by a one-cycle start pulse. It begins at a shared start PC and runs until it issues the instruction at a shared end PC. After that the warp is finished for good. A done flag rises when the last warp has finished and the pipeline has drained.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, `issueValid`, `complValid` and `done` are low, and both counters read zero.
- R2: A `warpStart[i]` pulse on a warp that has never started makes the warp eligible from the next cycle, with its PC set to `startPc`. A pulse on a warp that is running or finished has no effect, and its PC sequence is unchanged.
- R3: At most one instruction issues per cycle. `issueWarp` carries the warp index and `issuePc` carries that warp's current PC. The warp's PC then advances by one.
- R4: An instruction issued in cycle t comes back as `complValid` with `complWarp` equal to its warp in cycle t+`PIPE_LAT`. The warp does not issue again before that cycle, and it may issue again in that same cycle, so a lone warp issues every `PIPE_LAT` cycles.
- R5: Selection is round-robin. The chosen warp is the first eligible warp in ascending index order, wrapping around, starting at the index after the warp that issued last. After reset the search starts at warp 0.
- R6: With at least `PIPE_LAT` warps running, an instruction issues in every cycle. With K running warps, where K is less than `PIPE_LAT`, each round of `PIPE_LAT` cycles holds K issues and `PIPE_LAT`-K idle slots.
- R7: `issuedCount` increases by one in each cycle that issues. `idleCount` increases by one in each cycle with no issue while at least one warp is running, meaning started and not yet finished.
- R8: A warp that issues its instruction at PC equal to `endPc` becomes finished and never issues again.
- R9: `done` is high exactly when at least one warp has finished, no warp is running and no instruction is in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| warpStart | input | NUM_WARPS | One-cycle start pulse per warp |
| startPc | input | PC_W | First PC given to a warp when it starts |
| endPc | input | PC_W | PC of the last instruction of every warp |
| issueValid | output | 1 | An instruction issues this cycle |
| issueWarp | output | $clog2(NUM_WARPS) | Index of the issuing warp |
| issuePc | output | PC_W | PC of the issued instruction |
| complValid | output | 1 | An instruction leaves the pipeline this cycle |
| complWarp | output | $clog2(NUM_WARPS) | Warp of the completing instruction |
| issuedCount | output | CNT_W | Number of issue slots used |
| idleCount | output | CNT_W | Number of idle slots while warps were running |
| done | output | 1 | All started work has finished and drained |

## Verification
The sensitive coincidence occurs when a warp's completion returns from the pipeline in the same cycle that the selector picks that warp again. The completion must clear the in-flight mark, and the new issue must set it again. The bench provokes this with exactly nine warps of four instructions each, which makes every completion coincide with the same warp's next issue. It judges the result by requiring 36 issues in 36 consecutive cycles in strict rotation with no idle slot. A single-warp run then checks the spacing of exactly `PIPE_LAT` cycles between issues and between each issue and its completion.

// File: rtl/wis_pkg.sv
package wis_pkg;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_RUN  = 2'd1,
    W_FIN  = 2'd2
  } warpState_e;

  typedef struct packed {
    logic issueEn;
    logic idleEn;
  } ctrlStrobe_t;

endpackage

// File: rtl/wis_rr_arbiter.sv
module wis_rr_arbiter #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] startIdx,
  output logic          grantValid,
  output logic [IW-1:0] grantIdx
);
  always_comb begin
    int idx;
    grantValid = 1'b0;
    grantIdx   = '0;
    for (int k = 0; k < N; k++) begin
      idx = int'(startIdx) + k;
      if (idx >= N) idx = idx - N;
      if (!grantValid && req[idx]) begin
        grantValid = 1'b1;
        grantIdx   = IW'(idx);
      end
    end
  end
endmodule

// File: rtl/wis_delay_line.sv
module wis_delay_line #(
  parameter int DEPTH = 9,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [W-1:0] inData,
  output logic         outValid,
  output logic [W-1:0] outData,
  output logic         anyValid
);
  logic [DEPTH-1:0]        stageVld;
  logic [DEPTH-1:0][W-1:0] stageDat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageVld <= '0;
      stageDat <= '0;
    end else begin
      stageVld[0] <= inValid;
      stageDat[0] <= inData;
      for (int s = 1; s < DEPTH; s++) begin
        stageVld[s] <= stageVld[s-1];
        stageDat[s] <= stageDat[s-1];
      end
    end
  end

  assign outValid = stageVld[DEPTH-1];
  assign outData  = stageDat[DEPTH-1];
  assign anyValid = |stageVld;
endmodule

// File: rtl/wis_control.sv
module wis_control
  import wis_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [N-1:0]  eligible,
  input  logic          anyRun,
  output ctrlStrobe_t   strobe,
  output logic [IW-1:0] pickWarp
);
  logic [IW-1:0] rrPtr;
  logic          pickValid;

  wis_rr_arbiter #(.N(N), .IW(IW)) u_arb (
    .req       (eligible),
    .startIdx  (rrPtr),
    .grantValid(pickValid),
    .grantIdx  (pickWarp)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (pickValid) begin
      rrPtr <= (pickWarp == IW'(N - 1)) ? '0 : pickWarp + 1'b1;
    end
  end

  always_comb begin
    strobe.issueEn = pickValid;
    strobe.idleEn  = !pickValid && anyRun;
  end
endmodule

// File: rtl/wis_datapath.sv
module wis_datapath
  import wis_pkg::*;
#(
  parameter int N     = 16,
  parameter int IW    = 4,
  parameter int LAT   = 9,
  parameter int PC_W  = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     warpStart,
  input  logic [PC_W-1:0]  startPc,
  input  logic [PC_W-1:0]  endPc,
  input  ctrlStrobe_t      strobe,
  input  logic [IW-1:0]    pickWarp,
  output logic [N-1:0]     eligible,
  output logic             anyRun,
  output logic [PC_W-1:0]  pickPc,
  output logic             complValid,
  output logic [IW-1:0]    complWarp,
  output logic [CNT_W-1:0] issuedCount,
  output logic [CNT_W-1:0] idleCount,
  output logic             done
);
  warpState_e              warpSt [N];
  logic [N-1:0]            busy;
  logic [N-1:0][PC_W-1:0]  pcArr;
  logic [N-1:0]            running;
  logic [N-1:0]            finished;
  logic                    pipeBusy;

  // per-warp context update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        warpSt[i] <= W_IDLE;
        busy[i]   <= 1'b0;
        pcArr[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        logic hit, back;
        hit  = strobe.issueEn && (pickWarp == IW'(i));
        back = complValid && (complWarp == IW'(i));
        unique case (warpSt[i])
          W_IDLE: if (warpStart[i]) begin
            warpSt[i] <= W_RUN;
            pcArr[i]  <= startPc;
          end
          W_RUN: begin
            if (hit) begin
              busy[i]  <= 1'b1;
              pcArr[i] <= pcArr[i] + 1'b1;
              if (pcArr[i] == endPc) warpSt[i] <= W_FIN;
            end else if (back) begin
              busy[i] <= 1'b0;
            end
          end
          default: if (back) busy[i] <= 1'b0;
        endcase
      end
    end
  end

  // eligibility: a returning completion frees the warp in the same cycle
  for (genvar g = 0; g < N; g++) begin : g_elig
    assign running[g]  = (warpSt[g] == W_RUN);
    assign finished[g] = (warpSt[g] == W_FIN);
    assign eligible[g] = running[g] &&
                         (!busy[g] || (complValid && complWarp == IW'(g)));
  end

  assign anyRun = |running;
  assign pickPc = pcArr[pickWarp];

  wis_delay_line #(.DEPTH(LAT), .W(IW)) u_pipe (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (strobe.issueEn),
    .inData  (pickWarp),
    .outValid(complValid),
    .outData (complWarp),
    .anyValid(pipeBusy)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      issuedCount <= '0;
      idleCount   <= '0;
    end else begin
      if (strobe.issueEn) issuedCount <= issuedCount + 1'b1;
      if (strobe.idleEn)  idleCount   <= idleCount + 1'b1;
    end
  end

  assign done = (|finished) && !anyRun && !pipeBusy;
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 16,
  parameter int PIPE_LAT  = 9,
  parameter int PC_W      = 16,
  parameter int CNT_W     = 32,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] warpStart,
  input  logic [PC_W-1:0]      startPc,
  input  logic [PC_W-1:0]      endPc,
  output logic                 issueValid,
  output logic [WID_W-1:0]     issueWarp,
  output logic [PC_W-1:0]      issuePc,
  output logic                 complValid,
  output logic [WID_W-1:0]     complWarp,
  output logic [CNT_W-1:0]     issuedCount,
  output logic [CNT_W-1:0]     idleCount,
  output logic                 done
);
  ctrlStrobe_t            strobe;
  logic [NUM_WARPS-1:0]   eligible;
  logic                   anyRun;
  logic [WID_W-1:0]       pickWarp;

  wis_control #(.N(NUM_WARPS), .IW(WID_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .eligible(eligible),
    .anyRun  (anyRun),
    .strobe  (strobe),
    .pickWarp(pickWarp)
  );

  wis_datapath #(
    .N(NUM_WARPS), .IW(WID_W), .LAT(PIPE_LAT), .PC_W(PC_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .warpStart  (warpStart),
    .startPc    (startPc),
    .endPc      (endPc),
    .strobe     (strobe),
    .pickWarp   (pickWarp),
    .eligible   (eligible),
    .anyRun     (anyRun),
    .pickPc     (issuePc),
    .complValid (complValid),
    .complWarp  (complWarp),
    .issuedCount(issuedCount),
    .idleCount  (idleCount),
    .done       (done)
  );

  assign issueValid = strobe.issueEn;
  assign issueWarp  = pickWarp;
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int NUM_WARPS = 16,
  parameter int PIPE_LAT  = 9,
  parameter int PC_W      = 16,
  parameter int CNT_W     = 32,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_WARPS-1:0] warpStart,
  input logic [PC_W-1:0]      startPc,
  input logic [PC_W-1:0]      endPc,
  input logic                 issueValid,
  input logic [WID_W-1:0]     issueWarp,
  input logic [PC_W-1:0]      issuePc,
  input logic                 complValid,
  input logic [WID_W-1:0]     complWarp,
  input logic [CNT_W-1:0]     issuedCount,
  input logic [CNT_W-1:0]     idleCount,
  input logic                 done
);
  logic [NUM_WARPS-1:0] shBusy;
  logic [NUM_WARPS-1:0] shFin;

  // shadow of in-flight and finished warps, rebuilt from the ports
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shBusy <= '0;
      shFin  <= '0;
    end else begin
      for (int i = 0; i < NUM_WARPS; i++) begin
        if (issueValid && issueWarp == WID_W'(i)) begin
          shBusy[i] <= 1'b1;
          if (issuePc == endPc) shFin[i] <= 1'b1;
        end else if (complValid && complWarp == WID_W'(i)) begin
          shBusy[i] <= 1'b0;
        end
      end
    end
  end

  p_no_early_reissue_r4: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && shBusy[issueWarp]) |-> (complValid && complWarp == issueWarp));

  p_compl_known_r4: assert property (@(posedge clk) disable iff (!rstN)
    complValid |-> shBusy[complWarp]);

  p_never_after_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> !shFin[issueWarp]);

  p_issued_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> issuedCount == $past(issuedCount) + 1'b1);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> $stable(idleCount));

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!issueValid && !complValid));
endmodule

bind warp_issue_sched wis_checker #(
  .NUM_WARPS(NUM_WARPS), .PIPE_LAT(PIPE_LAT), .PC_W(PC_W), .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/tb_warp_issue_sched.sv
`timescale 1ns/1ps
module tb_warp_issue_sched;
  localparam int NW  = 16;
  localparam int LAT = 9;
  localparam int PW  = 16;
  localparam int CW  = 32;
  localparam int IW  = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NW-1:0] warpStart = '0;
  logic [PW-1:0] startPc = '0;
  logic [PW-1:0] endPc = '0;
  logic          issueValid, complValid, done;
  logic [IW-1:0] issueWarp, complWarp;
  logic [PW-1:0] issuePc;
  logic [CW-1:0] issuedCount, idleCount;

  warp_issue_sched #(.NUM_WARPS(NW), .PIPE_LAT(LAT), .PC_W(PW), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .warpStart(warpStart), .startPc(startPc), .endPc(endPc),
    .issueValid(issueValid), .issueWarp(issueWarp), .issuePc(issuePc),
    .complValid(complValid), .complWarp(complWarp),
    .issuedCount(issuedCount), .idleCount(idleCount), .done(done));

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nLog = 0, nC = 0;
  int logW [1024];
  int logPc [1024];
  int logCyc [1024];
  int cW [1024];
  int cCyc [1024];

  always @(negedge clk) begin
    #1;
    if (rstN && issueValid && nLog < 1024) begin
      logW[nLog] = int'(issueWarp); logPc[nLog] = int'(issuePc); logCyc[nLog] = cyc;
      nLog = nLog + 1;
    end
    if (rstN && complValid && nC < 1024) begin
      cW[nC] = int'(complWarp); cCyc[nC] = cyc;
      nC = nC + 1;
    end
  end

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; warpStart = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [NW-1:0] m);
    warpStart = m;
    @(negedge clk);
    warpStart = '0;
  endtask

  task automatic t_reset();
    doReset();
    chk(issueValid == 0, "R1", "issueValid", issueValid, 0);
    chk(complValid == 0, "R1", "complValid", complValid, 0);
    chk(done == 0, "R1", "done", done, 0);
    chk(issuedCount == 0 && idleCount == 0, "R1", "counters", issuedCount + idleCount, 0);
  endtask

  task automatic t_single();
    int b, bc;
    doReset();
    startPc = 10; endPc = 12;
    b = nLog; bc = nC;
    pulse(NW'(1) << 3);
    repeat (5) @(negedge clk);
    chk(done == 0, "R9", "done while running", done, 0);
    repeat (35) @(negedge clk);
    chk(nLog - b == 3, "R3", "single warp issue count", nLog - b, 3);
    for (int k = 0; k < 3; k++) begin
      chk(logW[b+k] == 3, "R3", "issue warp id", logW[b+k], 3);
      chk(logPc[b+k] == 10 + k, "R2", "issue pc", logPc[b+k], 10 + k);
    end
    chk(logCyc[b+1] - logCyc[b] == LAT, "R4", "reissue spacing", logCyc[b+1] - logCyc[b], LAT);
    chk(nC - bc == 3, "R4", "completion count", nC - bc, 3);
    chk(cCyc[bc] - logCyc[b] == LAT && cW[bc] == 3, "R4", "completion delay",
        cCyc[bc] - logCyc[b], LAT);
    chk(issuedCount == 3, "R7", "issuedCount", issuedCount, 3);
    chk(idleCount == 16, "R7", "idleCount lone warp", idleCount, 16);
    chk(done == 1, "R9", "done after drain", done, 1);
    b = nLog;
    pulse(NW'(1) << 3);
    repeat (20) @(negedge clk);
    chk(nLog == b, "R8", "finished warp restarted", nLog - b, 0);
    chk(issuedCount == 3, "R8", "issuedCount after restart pulse", issuedCount, 3);
  endtask

  task automatic t_full();
    int b, gaps, bad;
    doReset();
    startPc = 0; endPc = 3;
    b = nLog;
    pulse(NW'(9'h1FF));
    repeat (60) @(negedge clk);
    chk(nLog - b == 36, "R6", "nine warps issue count", nLog - b, 36);
    gaps = 0; bad = 0;
    for (int k = 1; k < 36; k++) if (logCyc[b+k] - logCyc[b+k-1] != 1) gaps++;
    for (int k = 0; k < 36; k++) if (logW[b+k] != k % 9 || logPc[b+k] != k / 9) bad++;
    chk(gaps == 0, "R6", "gaps with nine warps", gaps, 0);
    chk(bad == 0, "R5", "rotation order mismatches", bad, 0);
    chk(idleCount == 0, "R6", "idleCount nine warps", idleCount, 0);
    chk(issuedCount == 36, "R7", "issuedCount nine warps", issuedCount, 36);
    chk(done == 1, "R9", "done nine warps", done, 1);
  endtask

  task automatic t_few();
    int b, bad;
    int exp [6] = '{0, 5, 10, 0, 5, 10};
    doReset();
    startPc = 0; endPc = 1;
    b = nLog;
    pulse(NW'(16'h0421));
    repeat (40) @(negedge clk);
    chk(nLog - b == 6, "R6", "three warps issue count", nLog - b, 6);
    bad = 0;
    for (int k = 0; k < 6; k++) if (logW[b+k] != exp[k]) bad++;
    chk(bad == 0, "R5", "three warp order", bad, 0);
    chk(logCyc[b+3] - logCyc[b] == LAT, "R4", "warp 0 spacing", logCyc[b+3] - logCyc[b], LAT);
    chk(idleCount == 6, "R6", "idle slots three warps", idleCount, 6);
  endtask

  task automatic t_all16();
    int b, bad;
    doReset();
    startPc = 7; endPc = 7;
    b = nLog;
    pulse('1);
    repeat (40) @(negedge clk);
    chk(nLog - b == 16, "R8", "one instruction per warp", nLog - b, 16);
    bad = 0;
    for (int k = 0; k < 16; k++) if (logW[b+k] != k || logPc[b+k] != 7) bad++;
    chk(bad == 0, "R5", "sixteen warp order", bad, 0);
    chk(logCyc[b+15] - logCyc[b] == 15, "R3", "one issue per cycle", logCyc[b+15] - logCyc[b], 15);
    chk(done == 1, "R9", "done sixteen warps", done, 1);
  endtask

  task automatic t_restartIgnored();
    int b, bad;
    doReset();
    startPc = 0; endPc = 2;
    b = nLog;
    pulse(NW'(1) << 2);
    repeat (2) @(negedge clk);
    startPc = 100;
    pulse(NW'(1) << 2);
    repeat (40) @(negedge clk);
    chk(nLog - b == 3, "R2", "running warp restart count", nLog - b, 3);
    bad = 0;
    for (int k = 0; k < 3; k++) if (logPc[b+k] != k) bad++;
    chk(bad == 0, "R2", "pc sequence kept", bad, 0);
  endtask

  task automatic t_pointer();
    int b;
    doReset();
    startPc = 0; endPc = 0;
    b = nLog;
    pulse(NW'(1) << 4);
    pulse((NW'(1) << 1) | (NW'(1) << 7));
    repeat (20) @(negedge clk);
    chk(nLog - b == 3, "R5", "pointer test count", nLog - b, 3);
    chk(logW[b] == 4, "R5", "first pick", logW[b], 4);
    chk(logW[b+1] == 7, "R5", "pick after last issued", logW[b+1], 7);
    chk(logW[b+2] == 1, "R5", "wrapped pick", logW[b+2], 1);
  endtask

  initial begin
    t_reset();
    t_single();
    t_full();
    t_few();
    t_all16();
    t_restartIgnored();
    t_pointer();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end
endmodule